// File: doc/BRIEF.md
# Segment Logical-to-Linear Translator

This block turns a logical address (a 16-bit segment selector and a 32-bit offset) into a 32-bit linear address. It decodes the selector and picks either the global or the local descriptor table. It fetches the 8-byte segment descriptor from that table over a single-cycle-latency memory read port and unpacks the base, limit and attribute fields. It then checks that the descriptor is present, checks the access kind and privilege against the descriptor's type and privilege fields, and compares the offset against the segment limit with granularity applied. If every check passes, it adds the base to the offset.

A requester offers one translation at a time under a valid/ready handshake, together with the access kind and the current privilege level. The global and local table base and limit values are plain inputs that stay stable while a translation is in flight. The answer comes back as a one-cycle response strobe that carries either the linear address or a fault code. A selector that fails the null or table-bound check is answered without any memory traffic.

Top module: `seg_xlate`

## Requirements
- R1: Selector bits [15:3] are the index, bit 2 picks the table (0 global, 1 local) and bits [1:0] are the requested privilege (RPL). The descriptor is read as a low word at table base + index*8, then a high word at that address + 4 on the next cycle. Read data returns one cycle after the read strobe.
- R2: A selector with index 0 and bit 2 clear faults with code 1 (null) and issues no memory read.
- R3: If index*8+7 exceeds the selected table's limit, the translation faults with code 2 (table bound) and issues no memory read.
- R4: Descriptor layout: the low word holds limit[15:0] in [15:0] and base[15:0] in [31:16]. The high word holds base[23:16] in [7:0], the attribute byte in [15:8] (bit 15 present, [14:13] DPL, bit 12 code/data flag S, [11:8] type) and limit[19:16] in [19:16]. It also holds granularity G in bit 23 and base[31:24] in [31:24]. A descriptor with present clear faults with code 3.
- R5: The effective limit is limit*4096+4095 when G=1, or the 20-bit limit when G=0. An offset above the effective limit faults with code 4.
- R6: Protection fault (code 5) applies to any access to a descriptor with S=0. It also applies to a write (kind 1) to a code segment (type bit 3 set) or to a data segment whose writable bit (type bit 1) is clear, and to a fetch (kind 2) from a data segment.
- R7: A read (kind 0) of a code segment whose readable bit (type bit 1) is clear raises a protection fault.
- R8: For reads and writes of data segments, and for reads of non-conforming code (type bit 2 clear), a protection fault is raised when max(CPL, RPL) > DPL.
- R9: A fetch from non-conforming code requires CPL = DPL. A fetch from conforming code (type bit 2 set) requires DPL <= CPL. RPL plays no part in fetches.
- R10: Fault priority is null, then table bound, then not present, then protection, then segment limit.
- R11: On success the linear address is base + offset modulo 2^32. A faulting response carries linear address 0. Selector 0x007B selects global index 15 with RPL 3, so a flat descriptor (base 0, limit 0xFFFFF, attributes 0xC0F2) returns the offset unchanged.
- R12: req_ready is high only when idle. rsp_valid is a one-cycle pulse. It arrives one cycle after acceptance for null and table-bound faults, and four cycles after acceptance otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset within the segment |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_cpl | input | 2 | Current privilege level |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | TLIM_W | Global table limit in bytes |
| ldt_base | input | 32 | Local table base address |
| ldt_limit | input | TLIM_W | Local table limit in bytes |
| mem_rd_en | output | 1 | Descriptor read strobe |
| mem_rd_addr | output | 32 | Descriptor word byte address |
| mem_rd_data | input | 32 | Read data, valid the cycle after the strobe |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 3 | 0 none, 1 null, 2 table bound, 3 not present, 4 limit, 5 protection |
| rsp_lin | output | 32 | Linear address, 0 on fault |

## Verification
The hardest case to reach is a descriptor that fails several checks at once, because only the fault with the highest priority may show. Examples are an absent descriptor with an offset past its limit, or an execute-only code segment read just beyond its limit. The bench builds a small set of descriptors that cover each type, privilege and granularity variant. It sweeps every access kind against every CPL and RPL pair. It then probes each descriptor exactly at and one past its effective limit, so the overlapping faults show up through rsp_fault. A high base plus a large offset exercises the wrap of the sum.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int ADDR_W = 32;
    localparam int SEL_W  = 16;
    localparam int IDX_W  = 13;
    localparam int LIM_W  = 20;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_EVAL
    } state_e;

    typedef enum logic [2:0] {
        F_NONE   = 3'd0,
        F_NULL   = 3'd1,
        F_TABLE  = 3'd2,
        F_ABSENT = 3'd3,
        F_LIMIT  = 3'd4,
        F_PROT   = 3'd5
    } fault_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              present;
        logic [1:0]        dpl;
        logic              seg;
        logic [3:0]        typ;
        logic              gran;
    } desc_t;

    typedef struct packed {
        state_e            state;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] off;
        logic [1:0]        kind;
        logic [1:0]        cpl;
        logic [1:0]        rpl;
        logic [31:0]       lo;
        logic              rsp_v;
        fault_e            rsp_f;
        logic [ADDR_W-1:0] rsp_lin;
    } regs_t;

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_xlate_pkg::*;
#(
    parameter int TLIM_W = 16
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [TLIM_W-1:0] gdt_limit,
    input  logic [ADDR_W-1:0] ldt_base,
    input  logic [TLIM_W-1:0] ldt_limit,
    output logic [ADDR_W-1:0] desc_addr,
    output logic [1:0]        rpl,
    output logic              null_sel,
    output logic              tbl_over
);
    localparam int PAD_W = ADDR_W - IDX_W - 3;

    logic [IDX_W-1:0]  idx;
    logic              use_local;
    logic [ADDR_W-1:0] tbl_base;
    logic [ADDR_W-1:0] tbl_lim;
    logic [ADDR_W-1:0] last_byte;

    always_comb begin
        idx       = sel[SEL_W-1:3];
        use_local = sel[2];
        rpl       = sel[1:0];
        tbl_base  = use_local ? ldt_base : gdt_base;
        tbl_lim   = use_local ? ADDR_W'(ldt_limit) : ADDR_W'(gdt_limit);
        desc_addr = tbl_base + {{PAD_W{1'b0}}, idx, 3'b000};
        last_byte = {{PAD_W{1'b0}}, idx, 3'b111};
        null_sel  = !use_local && (idx == '0);
        tbl_over  = last_byte > tbl_lim;
    end

endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
    import seg_xlate_pkg::*;
(
    input  logic [31:0]       lo,
    input  logic [31:0]       hi,
    input  logic [ADDR_W-1:0] off,
    input  logic [1:0]        kind,
    input  logic [1:0]        cpl,
    input  logic [1:0]        rpl,
    output fault_e            fault,
    output logic [ADDR_W-1:0] lin
);
    desc_t             d;
    logic [ADDR_W-1:0] eff_lim;
    logic [1:0]        eff_pl;
    logic              is_code;
    logic              conform;
    logic              rw_bit;
    logic              prot;
    logic              unused_bits;

    always_comb begin
        d.limit   = {hi[19:16], lo[15:0]};
        d.base    = {hi[31:24], hi[7:0], lo[31:16]};
        d.present = hi[15];
        d.dpl     = hi[14:13];
        d.seg     = hi[12];
        d.typ     = hi[11:8];
        d.gran    = hi[23];
        unused_bits = ^{hi[22:20], d.typ[0]};

        eff_lim = d.gran ? {d.limit, 12'hFFF} : {12'h000, d.limit};
        eff_pl  = (cpl > rpl) ? cpl : rpl;
        is_code = d.typ[3];
        conform = d.typ[2];
        rw_bit  = d.typ[1];

        if (!d.seg) begin
            prot = 1'b1;
        end else begin
            unique case (kind)
                2'd0:    prot = is_code ? (!rw_bit || (!conform && eff_pl > d.dpl))
                                        : (eff_pl > d.dpl);
                2'd1:    prot = is_code || !rw_bit || (eff_pl > d.dpl);
                default: prot = !is_code || (conform ? (d.dpl > cpl) : (d.dpl != cpl));
            endcase
        end

        if (!d.present)        fault = F_ABSENT;
        else if (prot)         fault = F_PROT;
        else if (off > eff_lim) fault = F_LIMIT;
        else                   fault = F_NONE;

        lin = (fault == F_NONE) ? d.base + off : '0;
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int TLIM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [15:0]       req_sel,
    input  logic [31:0]       req_off,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_cpl,
    input  logic [31:0]       gdt_base,
    input  logic [TLIM_W-1:0] gdt_limit,
    input  logic [31:0]       ldt_base,
    input  logic [TLIM_W-1:0] ldt_limit,
    output logic              mem_rd_en,
    output logic [31:0]       mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              rsp_valid,
    output logic [2:0]        rsp_fault,
    output logic [31:0]       rsp_lin
);
    regs_t q, d;

    logic [ADDR_W-1:0] sel_addr;
    logic [1:0]        sel_rpl;
    logic              sel_null;
    logic              sel_over;
    fault_e            chk_fault;
    logic [ADDR_W-1:0] chk_lin;

    seg_sel_decode #(.TLIM_W(TLIM_W)) u_dec (
        .sel       (req_sel),
        .gdt_base  (gdt_base),
        .gdt_limit (gdt_limit),
        .ldt_base  (ldt_base),
        .ldt_limit (ldt_limit),
        .desc_addr (sel_addr),
        .rpl       (sel_rpl),
        .null_sel  (sel_null),
        .tbl_over  (sel_over)
    );

    seg_desc_check u_chk (
        .lo    (q.lo),
        .hi    (mem_rd_data),
        .off   (q.off),
        .kind  (q.kind),
        .cpl   (q.cpl),
        .rpl   (q.rpl),
        .fault (chk_fault),
        .lin   (chk_lin)
    );

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr = sel_addr;
                    d.off  = req_off;
                    d.kind = req_kind;
                    d.cpl  = req_cpl;
                    d.rpl  = sel_rpl;
                    if (sel_null || sel_over) begin
                        d.rsp_v   = 1'b1;
                        d.rsp_f   = sel_null ? F_NULL : F_TABLE;
                        d.rsp_lin = '0;
                    end else begin
                        d.state = ST_RD_LO;
                    end
                end
            end
            ST_RD_LO: d.state = ST_RD_HI;
            ST_RD_HI: begin
                d.lo    = mem_rd_data;
                d.state = ST_EVAL;
            end
            default: begin
                d.rsp_v   = 1'b1;
                d.rsp_f   = chk_fault;
                d.rsp_lin = chk_lin;
                d.state   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, rsp_f: F_NONE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.state == ST_IDLE);
    assign mem_rd_en   = (q.state == ST_RD_LO) || (q.state == ST_RD_HI);
    assign mem_rd_addr = (q.state == ST_RD_HI) ? q.addr + 32'd4 : q.addr;
    assign rsp_valid   = q.rsp_v;
    assign rsp_fault   = q.rsp_f;
    assign rsp_lin     = q.rsp_lin;

    // R1: second descriptor word follows the first at +4
    a_r1_word_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + 32'd4));

    // R2: null selector answered on the next cycle with code 1
    a_r2_null_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_sel[15:3] == 13'd0 && !req_sel[2])
        |=> (rsp_valid && rsp_fault == 3'd1 && !mem_rd_en));

    // R11: faulting responses carry a zero linear address
    a_r11_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> (rsp_lin == 32'd0));

    // R12: after acceptance the block is either busy or answering
    a_r12_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready || rsp_valid));

    // R12: responses appear only while idle, never during descriptor reads
    a_r12_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (req_ready && !mem_rd_en));

endmodule

// File: tb/seg_xlate_test.sv
module seg_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_sel = '0;
    logic [31:0] req_off = '0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_cpl = '0;
    logic [31:0] gdt_base = 32'h0000_0000;
    logic [15:0] gdt_limit = 16'h007F;
    logic [31:0] ldt_base = 32'h0000_0080;
    logic [15:0] ldt_limit = 16'h003F;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data;
    logic        rsp_valid;
    logic [2:0]  rsp_fault;
    logic [31:0] rsp_lin;

    int vectors = 0;
    int fails   = 0;

    logic [31:0] mem [0:63];
    logic [31:0] rd_q = '0;

    logic [31:0] sh_base [0:31];
    logic [19:0] sh_lim  [0:31];
    logic [7:0]  sh_attr [0:31];
    logic [3:0]  sh_flg  [0:31];

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (mem_rd_en) rd_q <= mem[mem_rd_addr[7:2]];
    end
    assign mem_rd_data = rd_q;

    seg_xlate #(.TLIM_W(16)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_sel(req_sel), .req_off(req_off), .req_kind(req_kind), .req_cpl(req_cpl),
        .gdt_base(gdt_base), .gdt_limit(gdt_limit),
        .ldt_base(ldt_base), .ldt_limit(ldt_limit),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_lin(rsp_lin)
    );

    // R4 layout: place a descriptor in memory and in the bench shadow
    task automatic put_desc(input logic ti, input int idx, input logic [31:0] base,
                            input logic [19:0] lim, input logic [7:0] attr, input logic [3:0] flg);
        logic [31:0] a;
        a = (ti ? ldt_base : gdt_base) + 32'(idx * 8);
        mem[a[7:2]]        = {base[15:0], lim[15:0]};
        mem[a[7:2] + 6'd1] = {base[31:24], flg, lim[19:16], attr, base[23:16]};
        sh_base[ti * 16 + idx] = base;
        sh_lim [ti * 16 + idx] = lim;
        sh_attr[ti * 16 + idx] = attr;
        sh_flg [ti * 16 + idx] = flg;
    endtask

    function automatic logic [31:0] eff_limit(input int e);
        return sh_flg[e][3] ? {sh_lim[e], 12'hFFF} : {12'h000, sh_lim[e]};
    endfunction

    // Expected {fault, linear} derived from the requirements
    function automatic logic [34:0] expect_rsp(input logic [15:0] sel, input logic [31:0] off,
                                               input logic [1:0] kind, input logic [1:0] cpl);
        int idx, e;
        logic ti, p, s, code, conf, rwb, bad;
        logic [1:0] rpl, dpl, pl;
        logic [31:0] tl;
        idx = int'(sel[15:3]);
        ti  = sel[2];
        rpl = sel[1:0];
        if (!ti && idx == 0) return {3'd1, 32'd0};
        tl = ti ? 32'(ldt_limit) : 32'(gdt_limit);
        if (32'(idx * 8 + 7) > tl) return {3'd2, 32'd0};
        e    = (ti ? 16 : 0) + idx;
        p    = sh_attr[e][7];
        dpl  = sh_attr[e][6:5];
        s    = sh_attr[e][4];
        code = sh_attr[e][3];
        conf = sh_attr[e][2];
        rwb  = sh_attr[e][1];
        pl   = (cpl > rpl) ? cpl : rpl;
        if (!p) return {3'd3, 32'd0};
        if (!s) bad = 1'b1;
        else if (kind == 2'd2) bad = !code || (conf ? (dpl > cpl) : (dpl != cpl));
        else if (kind == 2'd1) bad = code || !rwb || (pl > dpl);
        else if (code) bad = !rwb || (!conf && pl > dpl);
        else bad = pl > dpl;
        if (bad) return {3'd5, 32'd0};
        if (off > eff_limit(e)) return {3'd4, 32'd0};
        return {3'd0, sh_base[e] + off};
    endfunction

    function automatic string tag_for(input logic [2:0] f, input logic [1:0] kind);
        case (f)
            3'd0: return "R11";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return (kind == 2'd2) ? "R9" : (kind == 2'd1) ? "R6" : "R8";
        endcase
    endfunction

    // Called at a falling edge while idle; returns at a falling edge
    task automatic run(input logic [15:0] sel, input logic [31:0] off,
                       input logic [1:0] kind, input logic [1:0] cpl, input string tag);
        logic [34:0] ex;
        int lat, exp_lat;
        string t;
        ex = expect_rsp(sel, off, kind, cpl);
        t  = (tag == "") ? tag_for(ex[34:32], kind) : tag;
        req_valid = 1'b1; req_sel = sel; req_off = off; req_kind = kind; req_cpl = cpl;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        vectors++;
        if (!rsp_valid || {rsp_fault, rsp_lin} != ex) begin
            fails++;
            $display("FAIL %s sel=%h off=%h kind=%0d cpl=%0d: got fault=%0d lin=%h, expected fault=%0d lin=%h",
                     t, sel, off, kind, cpl, rsp_fault, rsp_lin, ex[34:32], ex[31:0]);
        end
        exp_lat = (ex[34:32] == 3'd1 || ex[34:32] == 3'd2) ? 1 : 4;
        vectors++;
        if (lat != exp_lat) begin
            fails++;
            $display("FAIL R12 latency sel=%h: got %0d, expected %0d", sel, lat, exp_lat);
        end
        if (rsp_valid) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        for (int i = 0; i < 32; i++) begin
            sh_base[i] = '0; sh_lim[i] = '0; sh_attr[i] = '0; sh_flg[i] = '0;
        end
        put_desc(0, 1,  32'h0000_0000, 20'hFFFFF, 8'hF2, 4'hC); // flat rw data DPL3
        put_desc(0, 2,  32'h0000_1000, 20'h00FFF, 8'h90, 4'h0); // read-only data DPL0
        put_desc(0, 3,  32'h0000_0000, 20'hFFFFF, 8'hFA, 4'hC); // readable code DPL3
        put_desc(0, 4,  32'h0000_2000, 20'h0FFFF, 8'h98, 4'h4); // execute-only code DPL0
        put_desc(0, 5,  32'h0000_0300, 20'h007FF, 8'hBE, 4'h4); // conforming readable code DPL1
        put_desc(0, 6,  32'h0000_0000, 20'h0FFFF, 8'h72, 4'h0); // absent data
        put_desc(0, 7,  32'h0000_4000, 20'h00067, 8'h89, 4'h0); // system descriptor
        put_desc(0, 8,  32'hFFFF_F000, 20'h01FFF, 8'hD2, 4'h0); // rw data DPL2, high base
        put_desc(0, 9,  32'h0001_0000, 20'h00003, 8'hB2, 4'h8); // rw data DPL1, page granular
        put_desc(0, 15, 32'h0000_0000, 20'hFFFFF, 8'hF2, 4'hC); // flat user data
        put_desc(1, 0,  32'h0000_5000, 20'h000FF, 8'hF2, 4'h0);
        put_desc(1, 3,  32'h0000_6000, 20'h0001F, 8'hF0, 4'h0);
        put_desc(1, 7,  32'h0000_7000, 20'h00FFF, 8'hF2, 4'h0);

        repeat (3) @(negedge clk);
        // R12 reset state
        vectors++;
        if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || mem_rd_en !== 1'b0) begin
            fails++;
            $display("FAIL R12 reset: got ready=%b rsp=%b rd=%b, expected 1 0 0",
                     req_ready, rsp_valid, mem_rd_en);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R11: 0x007B decodes to global index 15, RPL 3, flat: linear equals offset
        run(16'h007B, 32'h1234_5678, 2'd0, 2'd3, "R11");
        run(16'h007B, 32'hFFFF_FFFF, 2'd1, 2'd3, "R11");
        // R2 null selectors; R3 table bounds
        run(16'h0000, 32'h0, 2'd0, 2'd0, "R2");
        run(16'h0003, 32'h0, 2'd1, 2'd3, "R2");
        run(16'h0080, 32'h0, 2'd0, 2'd0, "R3");
        run(16'h0044, 32'h0, 2'd0, 2'd0, "R3");
        run(16'h003F, 32'h10, 2'd0, 2'd3, "R3");
        // R1: local index 0 is a valid entry, not a null selector
        run(16'h0007, 32'h20, 2'd0, 2'd3, "R1");
        // R4: an empty global slot reads as absent
        run(16'h0050, 32'h0, 2'd0, 2'd0, "R4");
        // R7: read of execute-only code
        run(16'h0020, 32'h0, 2'd0, 2'd0, "R7");
        // R11: base plus offset wraps modulo 2^32
        run(16'h0040, 32'h0000_1FFF, 2'd1, 2'd2, "R11");

        // R6 R8 R9: every kind against every CPL/RPL pair on each descriptor
        for (int i = 1; i <= 9; i++)
            for (int k = 0; k < 3; k++)
                for (int c = 0; c < 4; c++)
                    for (int r = 0; r < 4; r++)
                        run({13'(i), 1'b0, 2'(r)}, 32'h10, 2'(k), 2'(c), "");
        // R1: the same sweep through the local table
        for (int j = 0; j < 3; j++)
            for (int k = 0; k < 3; k++)
                for (int c = 0; c < 4; c++)
                    for (int r = 0; r < 4; r++)
                        run({13'((j == 0) ? 0 : (j == 1) ? 3 : 7), 1'b1, 2'(r)}, 32'h10, 2'(k), 2'(c), "R1");

        // R5 and R10: offsets at and just past each effective limit
        for (int i = 1; i <= 9; i++) begin
            run({13'(i), 3'b000}, eff_limit(i), 2'd0, 2'd0, "R5");
            if (eff_limit(i) != 32'hFFFF_FFFF)
                run({13'(i), 3'b000}, eff_limit(i) + 32'd1, 2'd0, 2'd0, "R10");
        end
        run(16'h001C, 32'h20, 2'd0, 2'd3, "R5");
        run(16'h001C, 32'h1F, 2'd1, 2'd3, "R10");
        run(16'h003C, 32'h1000, 2'd1, 2'd3, "R5");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule